// File: doc/BRIEF.md
# Banked RAM Window Mapper

This block extends the 16-bit address of an 8-bit processor so that it can reach a 512 KB RAM. The lower 32 KB of processor address space is RAM and is split into two 16 KB windows. The lower window always lands on physical page 0. The upper window lands on the page held in a 5-bit bank register. That register is written and read by software through its own I/O select.

Processor address bits 13:0 go to the RAM directly. This block supplies only the five physical address bits above them and the readback byte for the bank register. Bit 14 of the processor address picks the window whenever the main decoder asserts its RAM select. A write lands in the register when the qualified write strobe falls.

Top module: `bankmap_window`

## Requirements
- R1: After reset the bank register holds 0: readback returns 0x00 and an upper-window RAM access drives `page_hi` = 0.
- R2: With `ram_sel` high and `cpu_addr[14]` = 0 (CPU range 0x0000 to 0x3FFF), `page_hi` is 0 for every bank register value.
- R3: With `ram_sel` high and `cpu_addr[14]` = 1 (CPU range 0x4000 to 0x7FFF), `page_hi` equals the bank register, combinationally in the same cycle.
- R4: The qualified write is `io_sel` high, `rd_wr` = 0 (write) and `bus_stb` high. When it falls, the register loads `data_in[4:0]` as sampled in the last clock cycle in which the qualified write was high. The new value is visible after the first clock edge at which the qualified write is seen low.
- R5: A strobe pulse with `io_sel` low, or with `rd_wr` = 1 (read), leaves the bank register unchanged.
- R6: With `ram_sel` low, `page_hi` is 0 whatever the address and the bank value.
- R7: With `io_sel` high and `rd_wr` = 1, `data_out` is {000, bank}, so bits 7:5 are zero. Otherwise `data_out` is 0x00.
- R8: Bank value 0 is legal and makes the upper window alias page 0, the same page as the lower window.
- R9: All 32 bank values 0 to 31 can be loaded and each one appears unchanged on `page_hi` in the upper window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor address bus |
| ram_sel | input | 1 | RAM select from the main address decoder, active high |
| io_sel | input | 1 | Bank register I/O select, active high |
| rd_wr | input | 1 | Transfer direction, 1 = read, 0 = write |
| bus_stb | input | 1 | Bus data strobe, active high |
| data_in | input | 8 | Processor write data |
| page_hi | output | 5 | Physical RAM address bits 18:14 |
| data_out | output | 8 | Bank register readback byte |

## Verification
`page_hi` and `data_out` are combinational, so the bench checks them in the same cycle in which it drives the address, select or direction. It samples them half a period later, on the falling clock edge. A register write takes effect on the clock edge that first sees the qualified strobe low. The bench raises the strobe on one falling edge and drops it on the next, and it replaces the data with a different value at the same moment. Its readback and mapping checks then run from the following falling edge onward. The mapping checks sweep all 32 bank values against addresses in both windows and against a deasserted RAM select.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;
   localparam int unsigned DEF_ADDR_W = 16;
   localparam int unsigned DEF_WIN_W  = 14;
   localparam int unsigned DEF_PAGE_W = 5;
   localparam int unsigned DEF_DATA_W = 8;

   typedef enum logic [1:0] {
      WIN_NONE  = 2'd0,
      WIN_FIXED = 2'd1,
      WIN_BANK  = 2'd2
   } win_sel_e;
endpackage

// File: rtl/bankmap_strobe_edge.sv
module bankmap_strobe_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic io_sel,
   input  logic rd_wr,
   input  logic bus_stb,
   output logic wr_qual,
   output logic wr_fall
);
   logic qual_d;

   assign wr_qual = io_sel & ~rd_wr & bus_stb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) qual_d <= 1'b0;
      else        qual_d <= wr_qual;
   end

   assign wr_fall = qual_d & ~wr_qual;
endmodule

// File: rtl/bankmap_bank_reg.sv
module bankmap_bank_reg #(
   parameter int unsigned PAGE_W = 5,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_qual,
   input  logic              wr_fall,
   input  logic [DATA_W-1:0] data_in,
   output logic [PAGE_W-1:0] bank_q
);
   logic [PAGE_W-1:0] hold_q;
   logic [DATA_W-1:0] unused_data;

   assign unused_data = data_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         bank_q <= '0;
      end else begin
         if (wr_qual) hold_q <= data_in[PAGE_W-1:0];
         if (wr_fall) bank_q <= hold_q;
      end
   end
endmodule

// File: rtl/bankmap_window_mux.sv
module bankmap_window_mux
   import bankmap_pkg::*;
#(
   parameter int unsigned PAGE_W = 5
) (
   input  logic              ram_sel,
   input  logic              win_bit,
   input  logic [PAGE_W-1:0] bank_q,
   output win_sel_e          win,
   output logic [PAGE_W-1:0] page_hi
);
   always_comb begin
      if (!ram_sel)     win = WIN_NONE;
      else if (win_bit) win = WIN_BANK;
      else              win = WIN_FIXED;
   end

   always_comb begin
      unique case (win)
         WIN_BANK: page_hi = bank_q;
         default:  page_hi = '0;
      endcase
   end
endmodule

// File: rtl/bankmap_readback.sv
module bankmap_readback #(
   parameter int unsigned PAGE_W = 5,
   parameter int unsigned DATA_W = 8
) (
   input  logic              io_sel,
   input  logic              rd_wr,
   input  logic [PAGE_W-1:0] bank_q,
   output logic [DATA_W-1:0] data_out
);
   logic rd_en;
   assign rd_en = io_sel & rd_wr;

   generate
      if (DATA_W > PAGE_W) begin : g_pad
         localparam int unsigned PAD_W = DATA_W - PAGE_W;
         assign data_out = rd_en ? {{PAD_W{1'b0}}, bank_q} : '0;
      end else begin : g_full
         assign data_out = rd_en ? bank_q : '0;
      end
   endgenerate
endmodule

// File: rtl/bankmap_window.sv
module bankmap_window
   import bankmap_pkg::*;
#(
   parameter int unsigned ADDR_W = DEF_ADDR_W,
   parameter int unsigned WIN_W  = DEF_WIN_W,
   parameter int unsigned PAGE_W = DEF_PAGE_W,
   parameter int unsigned DATA_W = DEF_DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              ram_sel,
   input  logic              io_sel,
   input  logic              rd_wr,
   input  logic              bus_stb,
   input  logic [DATA_W-1:0] data_in,
   output logic [PAGE_W-1:0] page_hi,
   output logic [DATA_W-1:0] data_out
);
   localparam int unsigned SEL_BIT = WIN_W;

   generate
      if (SEL_BIT >= ADDR_W) begin : g_bad_win
         $error("window width must leave a select bit inside the address");
      end
      if (PAGE_W > DATA_W) begin : g_bad_page
         $error("bank register must fit in the data bus");
      end
      if (PAGE_W == 0) begin : g_bad_zero
         $error("bank register needs at least one bit");
      end
   endgenerate

   logic              wr_qual;
   logic              wr_fall;
   logic [PAGE_W-1:0] bank_q;
   win_sel_e          win;
   logic [ADDR_W-1:0] unused_addr;
   win_sel_e          unused_win;

   assign unused_addr = cpu_addr;
   assign unused_win  = win;

   bankmap_strobe_edge i_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .io_sel  (io_sel),
      .rd_wr   (rd_wr),
      .bus_stb (bus_stb),
      .wr_qual (wr_qual),
      .wr_fall (wr_fall)
   );

   bankmap_bank_reg #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) i_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_qual (wr_qual),
      .wr_fall (wr_fall),
      .data_in (data_in),
      .bank_q  (bank_q)
   );

   bankmap_window_mux #(.PAGE_W(PAGE_W)) i_mux (
      .ram_sel (ram_sel),
      .win_bit (cpu_addr[SEL_BIT]),
      .bank_q  (bank_q),
      .win     (win),
      .page_hi (page_hi)
   );

   bankmap_readback #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) i_rb (
      .io_sel   (io_sel),
      .rd_wr    (rd_wr),
      .bank_q   (bank_q),
      .data_out (data_out)
   );
endmodule

// File: rtl/bankmap_window_chk.sv
module bankmap_window_chk #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned WIN_W  = 14,
   parameter int unsigned PAGE_W = 5,
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              ram_sel,
   input logic              io_sel,
   input logic              rd_wr,
   input logic              bus_stb,
   input logic [DATA_W-1:0] data_in,
   input logic [PAGE_W-1:0] page_hi,
   input logic [DATA_W-1:0] data_out,
   input logic [PAGE_W-1:0] bank_q
);
   logic qual;
   logic started;
   assign qual = io_sel & ~rd_wr & bus_stb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) started <= 1'b0;
      else        started <= 1'b1;
   end

   AST_RESET_ZERO: assert property (@(posedge clk) !started |-> bank_q == '0); // R1
   AST_FIXED_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      ram_sel && !cpu_addr[WIN_W] |-> page_hi == '0); // R2
   AST_BANK_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      ram_sel && cpu_addr[WIN_W] |-> page_hi == bank_q); // R3
   AST_LOAD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      started && $past(started) && $past(qual) && !qual |=> bank_q == $past(data_in[PAGE_W-1:0], 2)); // R4
   AST_HOLD_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
      started && !($past(qual) && !qual) |=> $stable(bank_q)); // R5
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_sel |-> page_hi == '0); // R6
   AST_READ_PAD: assert property (@(posedge clk) disable iff (!rst_n)
      io_sel && rd_wr |-> data_out[DATA_W-1:PAGE_W] == '0); // R7
   AST_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_sel && rd_wr) |-> data_out == '0); // R7
endmodule

bind bankmap_window bankmap_window_chk #(
   .ADDR_W(ADDR_W), .WIN_W(WIN_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cpu_addr (cpu_addr),
   .ram_sel  (ram_sel),
   .io_sel   (io_sel),
   .rd_wr    (rd_wr),
   .bus_stb  (bus_stb),
   .data_in  (data_in),
   .page_hi  (page_hi),
   .data_out (data_out),
   .bank_q   (bank_q)
);

// File: tb/test_bankmap_window.sv
`timescale 1ns/1ps
module test_bankmap_window;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        ram_sel = 1'b0;
   logic        io_sel = 1'b0;
   logic        rd_wr = 1'b1;
   logic        bus_stb = 1'b0;
   logic [7:0]  data_in = '0;
   logic [4:0]  page_hi;
   logic [7:0]  data_out;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   bankmap_window i_bankmap_window (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .ram_sel(ram_sel),
      .io_sel(io_sel), .rd_wr(rd_wr), .bus_stb(bus_stb), .data_in(data_in),
      .page_hi(page_hi), .data_out(data_out)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // strobe high for one cycle, then low with changed data
   task automatic bus_pulse(input logic sel, input logic rw, input logic [7:0] d);
      @(negedge clk);
      io_sel = sel; rd_wr = rw; bus_stb = 1'b1; data_in = d;
      @(negedge clk);
      bus_stb = 1'b0; data_in = ~d;
      @(negedge clk);
      io_sel = 1'b0; rd_wr = 1'b1;
   endtask

   task automatic read_bank(output int v);
      io_sel = 1'b1; rd_wr = 1'b1;
      #1;
      v = data_out;
      io_sel = 1'b0;
      #0;
   endtask

   task automatic map(input logic rs, input logic [15:0] a, output int v);
      ram_sel = rs; cpu_addr = a;
      #1;
      v = page_hi;
   endtask

   initial begin
      int v;
      int exp_bank;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      read_bank(v);          chk("R1 reset readback", v, 0);
      map(1'b1, 16'h4000, v); chk("R1 reset upper window", v, 0);

      exp_bank = 0;
      for (int b = 0; b < 32; b++) begin
         bus_pulse(1'b1, 1'b0, 8'(b) | 8'hE0);
         exp_bank = b;
         @(negedge clk);
         read_bank(v); chk("R4/R7 readback after write", v, exp_bank);
         for (int k = 0; k < 8; k++) begin
            logic [15:0] lo;
            logic [15:0] hi;
            lo = 16'(k * 16'h0813) & 16'h3FFF;
            hi = lo | 16'h4000;
            map(1'b1, lo, v); chk("R2 fixed window", v, 0);
            map(1'b1, hi, v); chk("R3/R9 banked window", v, exp_bank);
            if (b == 0) chk("R8 bank 0 aliases page 0", v, 0);
            map(1'b0, hi | 16'(k << 15), v); chk("R6 ram_sel low", v, 0);
         end
      end

      bus_pulse(1'b1, 1'b0, 8'h0B);
      exp_bank = 11;
      @(negedge clk);
      bus_pulse(1'b0, 1'b0, 8'h15);
      @(negedge clk);
      read_bank(v); chk("R5 write without io_sel ignored", v, exp_bank);
      map(1'b1, 16'h7FFF, v); chk("R5 mapping unchanged", v, exp_bank);
      bus_pulse(1'b1, 1'b1, 8'h1C);
      @(negedge clk);
      read_bank(v); chk("R5 read strobe ignored", v, exp_bank);

      io_sel = 1'b0; rd_wr = 1'b1; #1;
      chk("R7 data_out idle", data_out, 0);
      io_sel = 1'b1; rd_wr = 1'b0; #1;
      chk("R7 data_out on write", data_out, 0);
      io_sel = 1'b0;

      // mid-write check: value not yet loaded while strobe still high
      @(negedge clk);
      io_sel = 1'b1; rd_wr = 1'b0; bus_stb = 1'b1; data_in = 8'h03;
      @(negedge clk);
      @(negedge clk);
      ram_sel = 1'b1; cpu_addr = 16'h4123; #1;
      chk("R4 no load while strobe high", page_hi, exp_bank);
      bus_stb = 1'b0;
      @(negedge clk);
      #1;
      chk("R4 load after fall", page_hi, 3);
      io_sel = 1'b0;

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule